// File: doc/BRIEF.md
# Four-Tap Polyphase Line Resampler

This block resizes one 8-bit channel of a scan line. Before a line is processed, a 32-word coefficient memory is filled through a simple write port. Each word describes one of 32 sub-sample phases as four signed 8-bit taps whose sum is 64. A line begins with a `start` pulse. This pulse captures the input width, the output width, the step and the starting position. The block then accepts exactly the requested number of input samples on a valid/ready stream and stores them locally. After that it emits exactly the requested number of resampled samples on a second valid/ready stream.

The read position is unsigned 16.16 fixed point. It begins at `initPos` and advances by `stepCfg` after every output that is taken. The usual step is the input width shifted left by 16 and divided by the output width. The integer part of the position selects the centre sample. The five fractional bits just below the binary point select the phase. Tap positions that fall outside the line reuse the nearest edge sample. The weighted sum is rounded and scaled by 1/64, then limited to the 8-bit range.

Top module: `poly4_resampler`

## Requirements
- R1: While `rst` is high, and after it is released until a `start` is taken, `inReady` and `outValid` are both low.
- R2: A `start` pulse while the block is idle opens the load phase. During this phase `inReady` is high, `outValid` is low, and exactly `inWidth` samples are accepted, one per cycle in which `inValid` and `inReady` are both high. `inReady` then goes low.
- R3: After the load phase, `outValid` stays high until exactly `outWidth` samples have been taken. The block then returns to idle, with both `inReady` and `outValid` low.
- R4: Output number j (counting from 0) uses position P = `initPos` + j·`stepCfg`, taken modulo 2^32. The centre index c is P[31:16] and the phase is P[15:11].
- R5: Byte 0 (bits 7:0) of the phase word weights sample c−1, byte 1 weights sample c, byte 2 weights c+1 and byte 3 weights c+2. Each byte is a two's-complement signed tap.
- R6: A phase word of 0x00004000 with a step of 0x00010000 and a start position of 0 reproduces the input line unchanged.
- R7: The output is (Σ tap·sample + 32) shifted right arithmetically by 6.
- R8: Results below 0 become 0 and results above 255 become 255.
- R9: A tap index below 0 reads sample 0, and a tap index above `inWidth`−1 reads sample `inWidth`−1.
- R10: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change.
- R11: A `start` pulse during the load or output phase is ignored, together with the configuration values presented with it.
- R12: When `coefWe` is high on a clock edge, `coefData` is written into phase word `coefAddr`, and later outputs that use that phase see the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line; captures the configuration below when idle |
| inWidth | input | 7 | Number of input samples in the line (1 to 64) |
| outWidth | input | 7 | Number of output samples in the line (1 to 64) |
| stepCfg | input | 32 | Position increment per output, unsigned 16.16 |
| initPos | input | 32 | Position of the first output, unsigned 16.16 |
| coefWe | input | 1 | Coefficient word write enable |
| coefAddr | input | 5 | Phase index to write |
| coefData | input | 32 | Four signed taps, byte 0 applied to sample c−1 |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block accepts an input sample |
| inData | input | 8 | Input sample |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Consumer takes the output sample |
| outData | output | 8 | Resampled output sample |

## Verification
The hardest cases to reach are those where several taps are replaced by the edge sample at once, and those where the weighted sum goes past either end of the 8-bit range. Normal filter tables rarely produce these. The bench reaches edge replication by starting a line with a start position beyond the last sample, and by upscaling so that the final outputs read past the end. It drives saturation by writing extreme tap words into phase 0 through the write port just before a line. It also stalls the output with an irregular `outReady` pattern, and pulses `start` with different settings in the middle of a load, to show that the captured line settings are kept.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } rsmpState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;     // capture step and start position
    logic pushSample;  // write inData into the line store
    logic stepOut;     // output taken, advance position
  } rsmpStrobe_t;

  localparam int POS_W  = 32;  // 16.16 position
  localparam int FRAC_W = 16;
  localparam int TAPS   = 4;
  localparam int TAP_W  = 8;
  localparam int PIX_W  = 8;

endpackage

// File: rtl/rsmp_ctrl.sv
module rsmp_ctrl
  import rsmp_pkg::*;
#(
  parameter int MAX_WIDTH = 64,
  localparam int CNT_W = $clog2(MAX_WIDTH + 1),
  localparam int IDX_W = $clog2(MAX_WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] inWidth,
  input  logic [CNT_W-1:0] outWidth,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output rsmpStrobe_t      ctl,
  output logic [IDX_W-1:0] sampleIdx,
  output logic [IDX_W-1:0] lastIdx
);

  rsmpState_t state;
  logic [CNT_W-1:0] inWidthQ;
  logic [CNT_W-1:0] outWidthQ;
  logic [IDX_W-1:0] inCnt;
  logic [CNT_W-1:0] outCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      inWidthQ  <= '0;
      outWidthQ <= '0;
      inCnt     <= '0;
      outCnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          inWidthQ  <= inWidth;
          outWidthQ <= outWidth;
          inCnt     <= '0;
          outCnt    <= '0;
          state     <= ST_LOAD;
        end
        ST_LOAD: if (inValid) begin
          inCnt <= inCnt + 1'b1;
          if (CNT_W'(inCnt) == inWidthQ - 1'b1) state <= ST_RUN;
        end
        ST_RUN: if (outReady) begin
          outCnt <= outCnt + 1'b1;
          if (outCnt == outWidthQ - 1'b1) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady        = (state == ST_LOAD);
    outValid       = (state == ST_RUN);
    ctl.loadCfg    = (state == ST_IDLE) && start;
    ctl.pushSample = inReady && inValid;
    ctl.stepOut    = outValid && outReady;
    sampleIdx      = inCnt;
    lastIdx        = IDX_W'(inWidthQ - 1'b1);
  end

endmodule

// File: rtl/rsmp_datapath.sv
module rsmp_datapath
  import rsmp_pkg::*;
#(
  parameter int MAX_WIDTH = 64,
  parameter int PHASES    = 32,
  localparam int IDX_W  = $clog2(MAX_WIDTH),
  localparam int PH_W   = $clog2(PHASES),
  localparam int WORD_W = TAPS * TAP_W,
  localparam int SIDX_W = POS_W - FRAC_W + 2,
  localparam int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  rsmpStrobe_t       ctl,
  input  logic [IDX_W-1:0]  sampleIdx,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [PIX_W-1:0]  inData,
  input  logic [POS_W-1:0]  stepCfg,
  input  logic [POS_W-1:0]  initPos,
  input  logic              coefWe,
  input  logic [PH_W-1:0]   coefAddr,
  input  logic [WORD_W-1:0] coefData,
  output logic [PIX_W-1:0]  outData
);

  logic [PIX_W-1:0]  lineBuf [MAX_WIDTH];
  logic [WORD_W-1:0] coefRam [PHASES];
  logic [POS_W-1:0]  posQ;
  logic [POS_W-1:0]  stepQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ  <= '0;
      stepQ <= '0;
    end else if (ctl.loadCfg) begin
      posQ  <= initPos;
      stepQ <= stepCfg;
    end else if (ctl.stepOut) begin
      posQ  <= posQ + stepQ;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.pushSample) lineBuf[sampleIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (coefWe) coefRam[coefAddr] <= coefData;
  end

  logic [POS_W-FRAC_W-1:0] centre;
  logic [PH_W-1:0]         phase;
  logic [WORD_W-1:0]       coefWord;
  logic signed [ACC_W-1:0] prod [TAPS];

  assign centre   = posQ[POS_W-1:FRAC_W];
  assign phase    = posQ[FRAC_W-1 -: PH_W];
  assign coefWord = coefRam[phase];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [SIDX_W-1:0] rawIdx;
    logic [IDX_W-1:0]         idx;
    logic signed [ACC_W-1:0]  tapExt;
    logic signed [ACC_W-1:0]  smpExt;

    always_comb begin
      rawIdx = $signed({2'b00, centre}) + SIDX_W'(k) - SIDX_W'(1);
      if (rawIdx < 0)
        idx = '0;
      else if (rawIdx > $signed({{(SIDX_W-IDX_W){1'b0}}, lastIdx}))
        idx = lastIdx;
      else
        idx = rawIdx[IDX_W-1:0];
      tapExt = {{(ACC_W-TAP_W){coefWord[k*TAP_W+TAP_W-1]}}, coefWord[k*TAP_W +: TAP_W]};
      smpExt = {{(ACC_W-PIX_W){1'b0}}, lineBuf[idx]};
    end

    assign prod[k] = tapExt * smpExt;
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rounded;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
    rounded = (acc + ACC_W'(32)) >>> 6;
    if (rounded < 0)
      outData = '0;
    else if (rounded > ACC_W'(255))
      outData = '1;
    else
      outData = rounded[PIX_W-1:0];
  end

endmodule

// File: rtl/poly4_resampler.sv
module poly4_resampler
  import rsmp_pkg::*;
#(
  parameter int MAX_WIDTH = 64,
  parameter int PHASES    = 32,
  localparam int CNT_W  = $clog2(MAX_WIDTH + 1),
  localparam int IDX_W  = $clog2(MAX_WIDTH),
  localparam int PH_W   = $clog2(PHASES),
  localparam int WORD_W = TAPS * TAP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  inWidth,
  input  logic [CNT_W-1:0]  outWidth,
  input  logic [POS_W-1:0]  stepCfg,
  input  logic [POS_W-1:0]  initPos,
  input  logic              coefWe,
  input  logic [PH_W-1:0]   coefAddr,
  input  logic [WORD_W-1:0] coefData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outData
);

  rsmpStrobe_t      ctl;
  logic [IDX_W-1:0] sampleIdx;
  logic [IDX_W-1:0] lastIdx;

  rsmp_ctrl #(.MAX_WIDTH(MAX_WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .inWidth(inWidth), .outWidth(outWidth),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid),
    .ctl(ctl), .sampleIdx(sampleIdx), .lastIdx(lastIdx)
  );

  rsmp_datapath #(.MAX_WIDTH(MAX_WIDTH), .PHASES(PHASES)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .sampleIdx(sampleIdx), .lastIdx(lastIdx), .inData(inData),
    .stepCfg(stepCfg), .initPos(initPos),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outData(outData)
  );

endmodule

// File: rtl/rsmp_checker.sv
module rsmp_checker (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData
);

  // R1: both streams quiet while reset is applied
  always @(negedge clk) begin
    if (rst === 1'b1) begin
      p_idle_in_reset_r1: assert (!inReady && !outValid);
    end
  end

  // R2: load and output phases never overlap
  p_phase_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R2: readiness is only withdrawn after a sample was taken
  p_ready_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (inReady && !inValid) |=> inReady);

  // R10: a stalled output stays offered
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);

  // R10: a stalled output keeps its value
  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outData));

endmodule

bind poly4_resampler rsmp_checker u_chk (
  .clk(clk), .rst(rst),
  .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady),
  .outData(outData)
);

// File: tb/tb_poly4_resampler.sv
`timescale 1ns/1ps
module tb_poly4_resampler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  inWidth = '0;
  logic [6:0]  outWidth = '0;
  logic [31:0] stepCfg = '0;
  logic [31:0] initPos = '0;
  logic        coefWe = 1'b0;
  logic [4:0]  coefAddr = '0;
  logic [31:0] coefData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outData;

  int checks = 0;
  int fails  = 0;

  logic [31:0] coefM [32];
  logic [7:0]  smp [64];

  always #4 clk = ~clk;

  poly4_resampler dut (
    .clk(clk), .rst(rst), .start(start),
    .inWidth(inWidth), .outWidth(outWidth),
    .stepCfg(stepCfg), .initPos(initPos),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int j, input int inW, input logic [31:0] stp,
                               input logic [31:0] ini);
    logic [31:0] p;
    int c, ph, acc, ix, tap, r;
    p   = ini + stp * 32'(j);
    c   = int'(p[31:16]);
    ph  = int'(p[15:11]);
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      ix = c + k - 1;
      if (ix < 0) ix = 0;
      if (ix > inW - 1) ix = inW - 1;
      tap = int'($signed(coefM[ph][8*k +: 8]));
      acc += tap * int'(smp[ix]);
    end
    r = (acc + 32) >>> 6;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic writeCoef(input int a, input logic [31:0] d);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 5'(a); coefData = d;
    coefM[a] = d;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  // taps: -e, 64-2p+e, 2p+e, -e with e = p(32-p)/64
  task automatic loadStdTable();
    for (int p = 0; p < 32; p++) begin
      int e, b;
      e = (p * (32 - p)) / 64;
      b = 2 * p;
      writeCoef(p, {8'(-e), 8'(b + e), 8'(64 - b + e), 8'(-e)});
    end
  endtask

  task automatic runLine(input int inW, input int outW, input logic [31:0] stp,
                         input logic [31:0] ini, input logic [7:0] pat,
                         input int pulseAt, input string tag);
    int i, j, cyc;
    bit r;
    @(negedge clk);
    start = 1'b1; inWidth = 7'(inW); outWidth = 7'(outW);
    stepCfg = stp; initPos = ini;
    @(negedge clk);
    start = 1'b0;
    i = 0; cyc = 0;
    while (i < inW && cyc < 2000) begin
      r = inReady;
      check(r, "R2 ready in load", int'(inReady), 1);
      check(!outValid, "R2 no output in load", int'(outValid), 0);
      inValid = 1'b1; inData = smp[i];
      if (i == pulseAt) begin
        // R11: different settings offered mid-load must be ignored
        start = 1'b1; inWidth = 7'd2; outWidth = 7'd9;
        stepCfg = 32'h0000_4000; initPos = 32'h0003_0000;
      end
      @(negedge clk);
      start = 1'b0;
      if (r) i++;
      cyc++;
    end
    inValid = 1'b0;
    check(!inReady, "R2 ready drops after last sample", int'(inReady), 0);
    j = 0; cyc = 0;
    while (j < outW && cyc < 5000) begin
      outReady = pat[cyc % 8];
      check(outValid, "R3 output offered", int'(outValid), 1);
      if (outValid) begin
        int e;
        e = model(j, inW, stp, ini);
        check(int'(outData) == e, tag, int'(outData), e);
        if (outReady) j++;
      end
      @(negedge clk);
      cyc++;
    end
    outReady = 1'b0;
    check(!outValid && !inReady, "R3 idle after exact count",
          int'({inReady, outValid}), 0);
  endtask

  task automatic testReset();
    check(!inReady && !outValid, "R1 reset quiet", int'({inReady, outValid}), 0);
    repeat (3) @(negedge clk);
    check(!inReady && !outValid, "R1 idle without start", int'({inReady, outValid}), 0);
  endtask

  task automatic testIdentity();
    for (int k = 0; k < 8; k++) smp[k] = 8'(17 + 29 * k);
    runLine(8, 8, 32'h0001_0000, 32'h0, 8'hFF, -1, "R6 passthrough");
  endtask

  task automatic testUpscale();
    for (int k = 0; k < 6; k++) smp[k] = 8'(k * 40 + (k % 2) * 13);
    runLine(6, 12, (32'd6 << 16) / 32'd12, 32'h0, 8'hFF, -1, "R5 R9 upscale");
  endtask

  task automatic testDownscale();
    for (int k = 0; k < 16; k++) smp[k] = 8'((k * 53) % 251);
    runLine(16, 5, (32'd16 << 16) / 32'd5, 32'h0000_4000, 8'hFF, -1, "R4 downscale");
  endtask

  task automatic testEdge();
    smp[0] = 8'd10; smp[1] = 8'd20; smp[2] = 8'd30; smp[3] = 8'd99;
    // start beyond the last sample: every tap reads sample 3
    runLine(4, 3, 32'h0000_8000, 32'h000A_0000, 8'hFF, -1, "R9 beyond end");
  endtask

  task automatic testClamp();
    for (int k = 0; k < 4; k++) smp[k] = 8'd200;
    writeCoef(0, 32'h7F7F7F7F);
    runLine(4, 4, 32'h0001_0000, 32'h0, 8'hFF, -1, "R8 R12 clamp high");
    writeCoef(0, 32'h80808080);
    runLine(4, 4, 32'h0001_0000, 32'h0, 8'hFF, -1, "R8 R12 clamp low");
    writeCoef(0, 32'h0000_4000);
  endtask

  task automatic testRounding();
    smp[0] = 8'd1; smp[1] = 8'd3; smp[2] = 8'd1; smp[3] = 8'd5;
    writeCoef(0, 32'h0000_2000);
    runLine(4, 4, 32'h0001_0000, 32'h0, 8'hFF, -1, "R7 round half up");
    writeCoef(0, 32'h0000_1F00);
    runLine(4, 4, 32'h0001_0000, 32'h0, 8'hFF, -1, "R7 round below half");
    writeCoef(0, 32'h0000_E040);
    runLine(4, 4, 32'h0001_0000, 32'h0, 8'hFF, -1, "R7 negative tap");
    writeCoef(0, 32'h0000_4000);
  endtask

  task automatic testBackpressure();
    for (int k = 0; k < 10; k++) smp[k] = 8'(250 - k * 23);
    runLine(10, 7, (32'd10 << 16) / 32'd7, 32'h0, 8'b0110_0101, -1, "R10 stalls");
  endtask

  task automatic testStartIgnored();
    for (int k = 0; k < 5; k++) smp[k] = 8'(5 + k * 50);
    runLine(5, 5, 32'h0001_0000, 32'h0, 8'hFF, 2, "R11 start ignored");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    loadStdTable();
    testIdentity();
    testUpscale();
    testDownscale();
    testEdge();
    testClamp();
    testRounding();
    testBackpressure();
    testStartIgnored();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule